// File: doc/BRIEF.md
# Flow Learn and Match Tag Unit

This unit sits between a packet inspection stage and a downstream packet processor. Each request carries an 8-bit classifier tag and a 96-bit flow key. The key is built from the IPv4 source address, the IPv4 destination address, the TCP source port and the TCP destination port. The two top bits of the tag are a command. A learn command records the flow key in a small fully associative table. A match command searches the table for the key. When the key is found, the storage slot becomes a second tag.

Every request produces one response word. The word joins the original classifier tag, the slot index and a hit bit, so the downstream processor gets the classification and the flow identity in one word. Requests may arrive on every cycle. Each response appears exactly two cycles after its request, and a request always sees every table change made by earlier requests.

Top module: `flow_tag_unit`

## Requirements
- R1: A stored key is found only when all 96 bits match; the key is {src_ip[31:0], dst_ip[31:0], src_port[15:0], dst_port[15:0]}, so a key that differs only in one port bit misses.
- R2: Tag bits 7:6 are the command: 01 is learn, 10 is match, 00 and 11 are no-ops. A no-op answers with hit=0 and index=0, and it leaves the table unchanged.
- R3: A learn of a new key stores the key in the lowest-numbered free slot and answers with hit=1 and that slot as the index.
- R4: A learn of a key that is already stored answers with hit=1 and the existing slot, and it does not use another slot.
- R5: A learn of a new key into a full 16-entry table answers with overflow=1, hit=0 and index=0, and it stores nothing.
- R6: A match answers with hit=1 and the slot index when the key is stored. Otherwise it answers with hit=0 and index=0. When several slots match, the lowest index wins.
- R7: The response word is {hit, index[3:0], tag[7:0]}. The request tag passes through into bits 7:0 unchanged.
- R8: A request sampled at one rising edge gives rsp_valid two rising edges later. Back-to-back requests are accepted, and a request sees the table updates of every earlier request.
- R9: Reset empties the table and clears rsp_valid, rsp_word and rsp_overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_tag | input | 8 | Classifier tag: command in 7:6, code in 5:0 |
| req_src_ip | input | 32 | IPv4 source address of the flow |
| req_dst_ip | input | 32 | IPv4 destination address of the flow |
| req_src_port | input | 16 | TCP source port |
| req_dst_port | input | 16 | TCP destination port |
| rsp_valid | output | 1 | Response present, two cycles after its request |
| rsp_word | output | 13 | {hit, index[3:0], tag[7:0]} |
| rsp_overflow | output | 1 | Learn refused because the table is full |

## Verification
A wrong valid bit or a corrupted stored key does not show at once. It shows at the first later match or learn of that key, as a hit where a miss is expected, as a wrong index, or as an overflow that comes too early or too late. A slot picked out of order shows on the very next learn response, and any later match of that key shows it again. The bench therefore learns keys and then matches them back to back, so that a table fault reaches the ports within two cycles of the request that exposes it.

// File: rtl/flow_tag_pkg.sv
package flow_tag_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_LEARN = 2'b01,
        CMD_MATCH = 2'b10,
        CMD_RSV   = 2'b11
    } flow_cmd_e;

endpackage

// File: rtl/flow_lowest_pick.sv
module flow_lowest_pick #(
    parameter int N     = 16,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Walk from the top down so that the lowest set bit is the one that remains.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/flow_key_table.sv
module flow_key_table #(
    parameter int KEY_W = 96,
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [KEY_W-1:0] cmp_key,
    output logic [DEPTH-1:0] hit_vec,
    output logic [DEPTH-1:0] valid_o
);

    typedef struct packed {
        logic [DEPTH-1:0]            valid;
        logic [DEPTH-1:0][KEY_W-1:0] keys;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.valid[wr_idx] = 1'b1;
            tbl_d.keys[wr_idx]  = wr_key;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = tbl_q.valid[g] && (tbl_q.keys[g] == cmp_key);
    end

    assign valid_o = tbl_q.valid;

    // R3: slots fill one at a time and never empty without reset
    assert_table_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(tbl_q.valid) & ~tbl_q.valid) == '0) &&
                 ($countones(tbl_q.valid) <= $countones($past(tbl_q.valid)) + 1));

    // R4: a write never lands on a slot that is already in use
    assert_no_dup_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !tbl_q.valid[wr_idx]);

endmodule

// File: rtl/flow_tag_unit.sv
module flow_tag_unit
    import flow_tag_pkg::*;
#(
    parameter int IP_W   = 32,
    parameter int PORT_W = 16,
    parameter int TAG_W  = 8,
    parameter int DEPTH  = 16,
    localparam int KEY_W  = 2 * IP_W + 2 * PORT_W,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int WORD_W = 1 + IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [IP_W-1:0]   req_src_ip,
    input  logic [IP_W-1:0]   req_dst_ip,
    input  logic [PORT_W-1:0] req_src_port,
    input  logic [PORT_W-1:0] req_dst_port,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_word,
    output logic              rsp_overflow
);

    typedef struct packed {
        logic             s1_valid;
        logic [TAG_W-1:0] s1_tag;
        logic [KEY_W-1:0] s1_key;
        logic             o_valid;
        logic             o_hit;
        logic [IDX_W-1:0] o_idx;
        logic [TAG_W-1:0] o_tag;
        logic             o_ovf;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [DEPTH-1:0] hit_vec;
    logic [DEPTH-1:0] tbl_valid;
    logic             any_hit, any_free;
    logic [IDX_W-1:0] hit_idx, free_idx;
    logic             wr_en_d;
    logic [IDX_W-1:0] wr_idx_d;
    flow_cmd_e        cmd;

    flow_key_table #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_d),
        .wr_idx  (wr_idx_d),
        .wr_key  (st_q.s1_key),
        .cmp_key (st_q.s1_key),
        .hit_vec (hit_vec),
        .valid_o (tbl_valid)
    );

    flow_lowest_pick #(.N(DEPTH), .IDX_W(IDX_W)) u_pick_hit (
        .vec   (hit_vec),
        .found (any_hit),
        .idx   (hit_idx)
    );

    flow_lowest_pick #(.N(DEPTH), .IDX_W(IDX_W)) u_pick_free (
        .vec   (~tbl_valid),
        .found (any_free),
        .idx   (free_idx)
    );

    assign cmd = flow_cmd_e'(st_q.s1_tag[TAG_W-1 -: 2]);

    always_comb begin
        st_d     = st_q;
        wr_en_d  = 1'b0;
        wr_idx_d = free_idx;

        // stage 1: capture the request
        st_d.s1_valid = req_valid;
        if (req_valid) begin
            st_d.s1_tag = req_tag;
            st_d.s1_key = {req_src_ip, req_dst_ip, req_src_port, req_dst_port};
        end

        // stage 2: search, update and form the response
        st_d.o_valid = st_q.s1_valid;
        st_d.o_tag   = st_q.s1_tag;
        st_d.o_hit   = 1'b0;
        st_d.o_idx   = '0;
        st_d.o_ovf   = 1'b0;
        if (st_q.s1_valid) begin
            unique case (cmd)
                CMD_LEARN: begin
                    if (any_hit) begin
                        st_d.o_hit = 1'b1;
                        st_d.o_idx = hit_idx;
                    end else if (any_free) begin
                        wr_en_d    = 1'b1;
                        st_d.o_hit = 1'b1;
                        st_d.o_idx = free_idx;
                    end else begin
                        st_d.o_ovf = 1'b1;
                    end
                end
                CMD_MATCH: begin
                    st_d.o_hit = any_hit;
                    st_d.o_idx = any_hit ? hit_idx : '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid    = st_q.o_valid;
    assign rsp_word     = {st_q.o_hit, st_q.o_idx, st_q.o_tag};
    assign rsp_overflow = st_q.o_ovf;

    // R8: a request always answers two edges later
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ##1 rsp_valid);

    // R8: no answer appears without a request
    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ##1 !rsp_valid);

    // R6: a miss carries index zero
    assert_miss_zero_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_word[WORD_W-1]) |-> (rsp_word[WORD_W-2 -: IDX_W] == '0));

    // R3: a reported slot is in use
    assert_hit_slot_used_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_word[WORD_W-1]) |-> tbl_valid[rsp_word[WORD_W-2 -: IDX_W]]);

    // R5: overflow only on a full table, without a hit
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_overflow |-> (rsp_valid && !rsp_word[WORD_W-1] && (&tbl_valid)));

    // R2: no-op commands never hit and never overflow
    assert_nop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_word[TAG_W-1 -: 2] == 2'b00 || rsp_word[TAG_W-1 -: 2] == 2'b11))
        |-> (!rsp_word[WORD_W-1] && !rsp_overflow));

endmodule

// File: tb/test_flow_tag_unit.sv
module test_flow_tag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_tag = '0;
    logic [31:0] req_src_ip = '0;
    logic [31:0] req_dst_ip = '0;
    logic [15:0] req_src_port = '0;
    logic [15:0] req_dst_port = '0;
    logic        rsp_valid;
    logic [12:0] rsp_word;
    logic        rsp_overflow;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    flow_tag_unit i_flow_tag_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_tag      (req_tag),
        .req_src_ip   (req_src_ip),
        .req_dst_ip   (req_dst_ip),
        .req_src_port (req_src_port),
        .req_dst_port (req_dst_port),
        .rsp_valid    (rsp_valid),
        .rsp_word     (rsp_word),
        .rsp_overflow (rsp_overflow)
    );

    // key id: bits 6:0 pick the flow, bit 7 flips the lowest destination port bit
    function automatic logic [95:0] mk_key(input logic [7:0] id);
        logic [31:0] s, d;
        logic [15:0] sp, dp;
        s  = 32'h0A00_0000 | {25'd0, id[6:0]};
        d  = 32'hC0A8_0100 | {25'd0, id[6:0]};
        sp = 16'd40000 + {9'd0, id[6:0]};
        dp = 16'd443 ^ {15'd0, id[7]};
        return {s, d, sp, dp};
    endfunction

    task automatic drive(input logic v, input logic [7:0] tag, input logic [7:0] id);
        logic [95:0] k;
        k = mk_key(id);
        req_valid    = v;
        req_tag      = tag;
        req_src_ip   = k[95:64];
        req_dst_ip   = k[63:32];
        req_src_port = k[31:16];
        req_dst_port = k[15:0];
    endtask

    task automatic check(input string req, input logic ev, input logic [12:0] ew, input logic eo);
        checks++;
        if (rsp_valid !== ev || (ev && (rsp_word !== ew || rsp_overflow !== eo))) begin
            errors++;
            $display("FAIL %s: actual valid=%b word=%h ovf=%b expected valid=%b word=%h ovf=%b",
                     req, rsp_valid, rsp_word, rsp_overflow, ev, ew, eo);
        end
    endtask

    // one isolated request; an idle check between request and answer
    task automatic single(input string req, input logic [7:0] tag, input logic [7:0] id,
                          input logic [12:0] ew, input logic eo);
        @(negedge clk);
        drive(1'b1, tag, id);
        @(negedge clk);
        drive(1'b0, 8'h00, 8'h00);
        check("R8 no early answer", 1'b0, 13'h0, 1'b0);
        @(negedge clk);
        check(req, 1'b1, ew, eo);
    endtask

    // {tag, key id, expected word, expected overflow}
    localparam int NV = 13;
    localparam logic [29:0] VEC [NV] = '{
        {8'h41, 8'd1,   1'b1, 4'd0, 8'h41, 1'b0},  // R3 first learn -> slot 0
        {8'h85, 8'd1,   1'b1, 4'd0, 8'h85, 1'b0},  // R8 back-to-back match sees learn
        {8'h42, 8'd2,   1'b1, 4'd1, 8'h42, 1'b0},  // R3 next free slot
        {8'h43, 8'd1,   1'b1, 4'd0, 8'h43, 1'b0},  // R4 relearn reports slot 0
        {8'h44, 8'd3,   1'b1, 4'd2, 8'h44, 1'b0},  // R4 no slot consumed
        {8'h8A, 8'd2,   1'b1, 4'd1, 8'h8A, 1'b0},  // R6 match hit
        {8'h80, 8'd9,   1'b0, 4'd0, 8'h80, 1'b0},  // R6 match miss
        {8'h01, 8'd4,   1'b0, 4'd0, 8'h01, 1'b0},  // R2 cmd 00
        {8'hC7, 8'd5,   1'b0, 4'd0, 8'hC7, 1'b0},  // R2 cmd 11, R7 tag passes
        {8'h82, 8'd4,   1'b0, 4'd0, 8'h82, 1'b0},  // R2 no-op stored nothing
        {8'h83, 8'd5,   1'b0, 4'd0, 8'h83, 1'b0},  // R2 no-op stored nothing
        {8'h45, 8'd4,   1'b1, 4'd3, 8'h45, 1'b0},  // R2 slot 3 still free
        {8'hBF, 8'h81,  1'b0, 4'd0, 8'hBF, 1'b0}   // R1 one port bit differs -> miss
    };

    initial begin
        drive(1'b0, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        check("R9 reset state", 1'b0, 13'h0, 1'b0);
        checks++;
        if (rsp_word !== 13'h0 || rsp_overflow !== 1'b0) begin
            errors++;
            $display("FAIL R9: actual word=%h ovf=%b expected word=0 ovf=0", rsp_word, rsp_overflow);
        end
        rst_n = 1'b1;

        // vector walk: request i driven in iteration i, answer checked in iteration i+2
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) check($sformatf("R7 vector %0d", i - 2), 1'b1, VEC[i-2][13:1], VEC[i-2][0]);
            if (i < NV) drive(1'b1, VEC[i][29:22], VEC[i][21:14]);
            else        drive(1'b0, 8'h00, 8'h00);
        end
        @(negedge clk);
        check("R8 idle after burst", 1'b0, 13'h0, 1'b0);

        // fill slots 4..15
        for (int k = 0; k < 12; k++)
            single("R3 fill", 8'h50, 8'(10 + k), {1'b1, 4'(4 + k), 8'h50}, 1'b0);
        single("R5 learn into full table", 8'h46, 8'd30, {1'b0, 4'd0, 8'h46}, 1'b1);
        single("R5 refused key not stored", 8'h84, 8'd30, {1'b0, 4'd0, 8'h84}, 1'b0);
        single("R6 match last slot", 8'h86, 8'd21, {1'b1, 4'd15, 8'h86}, 1'b0);
        single("R4 relearn on full table", 8'h47, 8'd21, {1'b1, 4'd15, 8'h47}, 1'b0);
        single("R1 exact key still hits", 8'h87, 8'd1, {1'b1, 4'd0, 8'h87}, 1'b0);

        // reset clears the table
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset mid run", 1'b0, 13'h0, 1'b0);
        rst_n = 1'b1;
        single("R9 table empty after reset", 8'h88, 8'd1, {1'b0, 4'd0, 8'h88}, 1'b0);
        single("R9 first learn after reset", 8'h48, 8'd50, {1'b1, 4'd0, 8'h48}, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule